// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block is the receive half of a UART-style serial channel. A two-stage synchronizer brings the serial line into the clock domain. A framer then waits for a falling edge and confirms the start bit halfway through its bit period. It collects the data bits least significant first, followed by an optional parity bit and one or two stop bits. All sampling uses a 16x oversampling tick supplied from outside.

When a frame ends, the flag stage decides what happens to it:

- **Clean frame:** the byte is moved into a holding register and a data-full flag is raised.
- **Data-full flag still set:** the new frame is dropped and an overrun flag is raised.
- **Bad stop bit or bad parity:** the byte is still moved, but the data-full flag stays low and the framing or parity flag is raised instead.

While any of the three error flags is set, no new frame is started. Each flag has its own single-cycle clear strobe. One enable input gates both the receive-complete and the receive-error interrupt lines.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, rx_data is 0, and full, ovr_err, frm_err, par_err, irq_done and irq_err are all 0.
- R2: A frame starts only on a high-to-low transition of the line. The line is checked again 8 ticks later. If it reads high there, the event is dropped as a glitch and no frame is received.
- R3: Data bits are taken least significant bit first. With cfg_len7=0 there are 8 bits. With cfg_len7=1 there are 7 bits, delivered in rx_data[6:0] with rx_data[7]=0.
- R4: With cfg_par_en=1, one parity bit follows the data. For cfg_par_odd=0 the count of ones over data plus parity must be even; for cfg_par_odd=1 it must be odd.
- R5: The first stop bit must read 1. With cfg_two_stop=1 a second stop bit period is awaited, but its value is never checked.
- R6: A frame with a good stop bit and good parity, ending while full=0, is written to rx_data and sets full=1.
- R7: A frame that ends while full=1 sets ovr_err. It leaves rx_data, frm_err and par_err unchanged.
- R8: A frame ending with full=0 and a bad stop bit or bad parity sets frm_err or par_err respectively. It still writes rx_data and leaves full at 0.
- R9: While any of ovr_err, frm_err or par_err is 1, no new frame is received; line activity changes neither rx_data nor full.
- R10: clr_full, clr_ovr, clr_frm and clr_par each clear their flag on the next clock edge. If the flag is set in the same cycle as its clear, the set wins.
- R11: irq_done is 1 exactly when irq_en=1 and full=1. irq_err is 1 exactly when irq_en=1 and any error flag is 1.
- R12: The configuration inputs are captured when a frame starts. Changing them mid-frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 16x oversampling strobe |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_len7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_two_stop | input | 1 | Two stop bits |
| irq_en | input | 1 | Enable for both interrupt outputs |
| clr_full | input | 1 | Clear strobe for full |
| clr_ovr | input | 1 | Clear strobe for ovr_err |
| clr_frm | input | 1 | Clear strobe for frm_err |
| clr_par | input | 1 | Clear strobe for par_err |
| rx_data | output | 8 | Received data register |
| full | output | 1 | Received data waiting |
| ovr_err | output | 1 | Overrun error flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| irq_done | output | 1 | Receive-complete interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
The assertions assume the line holds each bit steady for a full 16-tick period, so that midpoint samples are well defined. They also assume the clear strobes are one-cycle pulses, except in the set-wins case they single out. The bench drives every bit for exactly 16 cycles with tick held high. It leaves the line idle for several cycles between frames, and changes configuration only between frames, except in the one test that checks the capture point.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic len7;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_cfg_t;

endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/urx_framer.sv
module urx_framer
    import urx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxs,
    input  logic          enable,
    input  rx_cfg_t       cfg,
    output logic          frame_done,
    output logic [DW-1:0] frame_data,
    output logic          stop_bad,
    output logic          par_bad,
    output logic          busy
);

    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int BW   = $clog2(DW + 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [BW-1:0] nbit;
        logic [DW-1:0] sr;
        logic          pbit;
        rx_cfg_t       cfg;
        logic          armed;
        logic          done;
        logic          sbad;
    } fr_t;

    fr_t d, q;

    logic          bit_end;
    logic          mid_start;
    logic [BW-1:0] last_bit;

    assign bit_end   = (q.cnt == CW'(OVS - 1));
    assign mid_start = (q.cnt == CW'(HALF - 1));
    assign last_bit  = q.cfg.len7 ? BW'(DW - 2) : BW'(DW - 1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (rxs) d.armed = 1'b1;
                if (tick && !rxs && q.armed && enable) begin
                    d.st    = ST_START;
                    d.cnt   = '0;
                    d.armed = 1'b0;
                    d.cfg   = cfg;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (mid_start) begin
                        d.cnt = '0;
                        if (rxs) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st   = ST_DATA;
                            d.nbit = '0;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt = '0;
                        d.sr  = {rxs, q.sr[DW-1:1]};
                        if (q.nbit == last_bit)
                            d.st = q.cfg.par_en ? ST_PAR : ST_STOP;
                        else
                            d.nbit = q.nbit + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt  = '0;
                        d.pbit = rxs;
                        d.st   = ST_STOP;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt  = '0;
                        d.done = 1'b1;
                        d.sbad = ~rxs;
                        d.st   = q.cfg.two_stop ? ST_STOP2 : ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP2: begin
                if (tick) begin
                    if (bit_end) begin
                        d.cnt = '0;
                        d.st  = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // Short frames sit in the upper bits of the shifter.
    assign frame_data = q.cfg.len7 ? {1'b0, q.sr[DW-1:1]} : q.sr;
    assign frame_done = q.done;
    assign stop_bad   = q.sbad;
    assign par_bad    = q.cfg.par_en & ((^frame_data) ^ q.pbit ^ q.cfg.par_odd);
    assign busy       = (q.st != ST_IDLE);

endmodule

// File: rtl/urx_flags.sv
module urx_flags #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic [DW-1:0] frame_data,
    input  logic          stop_bad,
    input  logic          par_bad,
    input  logic          clr_full,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    input  logic          irq_en,
    output logic [DW-1:0] rx_data,
    output logic          full,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          par_err,
    output logic          irq_done,
    output logic          irq_err,
    output logic          rx_enable
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          ovr;
        logic          frm;
        logic          par;
    } fl_t;

    fl_t d, q;
    logic any_err;

    always_comb begin
        d = q;
        // Clears first, so a set below overrides them.
        if (clr_full) d.full = 1'b0;
        if (clr_ovr)  d.ovr  = 1'b0;
        if (clr_frm)  d.frm  = 1'b0;
        if (clr_par)  d.par  = 1'b0;
        if (frame_done) begin
            if (q.full) begin
                d.ovr = 1'b1;
            end else begin
                d.data = frame_data;
                if (stop_bad) d.frm = 1'b1;
                if (par_bad)  d.par = 1'b1;
                if (!stop_bad && !par_bad) d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign any_err   = q.ovr | q.frm | q.par;
    assign rx_data   = q.data;
    assign full      = q.full;
    assign ovr_err   = q.ovr;
    assign frm_err   = q.frm;
    assign par_err   = q.par;
    assign irq_done  = irq_en & q.full;
    assign irq_err   = irq_en & any_err;
    assign rx_enable = ~any_err;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import urx_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          cfg_len7,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    input  logic          irq_en,
    input  logic          clr_full,
    input  logic          clr_ovr,
    input  logic          clr_frm,
    input  logic          clr_par,
    output logic [DW-1:0] rx_data,
    output logic          full,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          par_err,
    output logic          irq_done,
    output logic          irq_err
);

    logic          rx_sync;
    logic          rx_enable;
    logic          fr_done;
    logic [DW-1:0] fr_data;
    logic          fr_stop_bad;
    logic          fr_par_bad;
    logic          fr_busy;
    rx_cfg_t       cfg_in;

    assign cfg_in = '{len7: cfg_len7, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    urx_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_sync)
    );

    urx_framer #(.OVS(OVS), .DW(DW)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rxs        (rx_sync),
        .enable     (rx_enable),
        .cfg        (cfg_in),
        .frame_done (fr_done),
        .frame_data (fr_data),
        .stop_bad   (fr_stop_bad),
        .par_bad    (fr_par_bad),
        .busy       (fr_busy)
    );

    urx_flags #(.DW(DW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (fr_done),
        .frame_data (fr_data),
        .stop_bad   (fr_stop_bad),
        .par_bad    (fr_par_bad),
        .clr_full   (clr_full),
        .clr_ovr    (clr_ovr),
        .clr_frm    (clr_frm),
        .clr_par    (clr_par),
        .irq_en     (irq_en),
        .rx_data    (rx_data),
        .full       (full),
        .ovr_err    (ovr_err),
        .frm_err    (frm_err),
        .par_err    (par_err),
        .irq_done   (irq_done),
        .irq_err    (irq_err),
        .rx_enable  (rx_enable)
    );

endmodule

// File: rtl/urx_checker.sv
module urx_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fr_done,
    input logic [DW-1:0] fr_data,
    input logic          fr_stop_bad,
    input logic          fr_par_bad,
    input logic          fr_busy,
    input logic          clr_full,
    input logic          clr_frm,
    input logic [DW-1:0] rx_data,
    input logic          full,
    input logic          ovr_err,
    input logic          frm_err,
    input logic          par_err,
    input logic          irq_done,
    input logic          irq_err
);

    assert_clean_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done && !full && !fr_stop_bad && !fr_par_bad
        |=> full && rx_data == $past(fr_data));

    assert_ovr_keeps_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done && full |=> ovr_err && $stable(rx_data));

    assert_err_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done && !full && (fr_stop_bad || fr_par_bad)
        |=> !full && (frm_err || par_err) && rx_data == $past(fr_data));

    assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err || frm_err || par_err) && !fr_busy |=> !fr_busy);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done && !full && !fr_stop_bad && !fr_par_bad && clr_full |=> full);

    assert_frm_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_frm && !fr_done |=> !frm_err);

    assert_irq_done_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> full);

    assert_irq_err_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (ovr_err || frm_err || par_err));

endmodule

bind uart_rx_core urx_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fr_done     (fr_done),
    .fr_data     (fr_data),
    .fr_stop_bad (fr_stop_bad),
    .fr_par_bad  (fr_par_bad),
    .fr_busy     (fr_busy),
    .clr_full    (clr_full),
    .clr_frm     (clr_frm),
    .rx_data     (rx_data),
    .full        (full),
    .ovr_err     (ovr_err),
    .frm_err     (frm_err),
    .par_err     (par_err),
    .irq_done    (irq_done),
    .irq_err     (irq_err)
);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rxd = 1'b1;
    logic       cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic       irq_en = 1'b0;
    logic       clr_full = 1'b0, clr_ovr = 1'b0, clr_frm = 1'b0, clr_par = 1'b0;
    logic [7:0] rx_data;
    logic       full, ovr_err, frm_err, par_err, irq_done, irq_err;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uart_rx_core dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .irq_en(irq_en),
        .clr_full(clr_full), .clr_ovr(clr_ovr), .clr_frm(clr_frm), .clr_par(clr_par),
        .rx_data(rx_data), .full(full), .ovr_err(ovr_err), .frm_err(frm_err),
        .par_err(par_err), .irq_done(irq_done), .irq_err(irq_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic line_bit(input logic v);
        rxd = v;
        repeat (16) @(negedge clk);
    endtask

    // nb data bits, optional parity (pflip inverts it), stop values s1/s2
    task automatic send(input logic [7:0] dat, input int nb, input bit pen, input bit podd,
                        input bit pflip, input bit s1, input bit two, input bit s2);
        logic p;
        p = podd;
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            line_bit(dat[i]);
            p = p ^ dat[i];
        end
        if (pen) line_bit(p ^ pflip);
        line_bit(s1);
        if (two) line_bit(s2);
        rxd = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_clr(input bit f, input bit o, input bit fr, input bit pa);
        clr_full = f; clr_ovr = o; clr_frm = fr; clr_par = pa;
        @(negedge clk);
        clr_full = 0; clr_ovr = 0; clr_frm = 0; clr_par = 0;
        @(negedge clk);
    endtask

    task automatic check_clean(input string req, input logic [7:0] exp);
        chk(req, rx_data, exp);
        chk(req, full, 1);
        chk(req, {ovr_err, frm_err, par_err}, 0);
        chk("R11", irq_done, irq_en);
        chk("R11", irq_err, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] m;
        bit got;
        repeat (3) @(negedge clk);
        irq_en = 1'b1;
        @(negedge clk);
        // R1 reset state, observed while reset is still held
        chk("R1", rx_data, 0);
        chk("R1", {full, ovr_err, frm_err, par_err}, 0);
        chk("R1", {irq_done, irq_err}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 R6: all bytes, 8N1
        for (int v = 0; v < 256; v++) begin
            irq_en = v[1];
            send(v[7:0], 8, 0, 0, 0, 1, 0, 1);
            check_clean("R6", v[7:0]);
            pulse_clr(1, 0, 0, 0);
            chk("R10", full, 0);
        end

        // R3 R4: all 7-bit values, odd parity
        cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 1;
        for (int v = 0; v < 128; v++) begin
            irq_en = v[0];
            send(v[7:0], 7, 1, 1, 0, 1, 0, 1);
            check_clean("R3", v[7:0]);
            pulse_clr(1, 0, 0, 0);
        end

        // R4 R5: 8 bits, even and odd parity, two stops (second sent as 0)
        cfg_len7 = 0; cfg_two_stop = 1;
        for (int po = 0; po < 2; po++) begin
            cfg_par_odd = po[0];
            for (int v = 3; v < 256; v += 23) begin
                irq_en = 1;
                send(v[7:0], 8, 1, po[0], 0, 1, 1, 0);
                check_clean("R5", v[7:0]);
                pulse_clr(1, 0, 0, 0);
            end
        end
        cfg_two_stop = 0;

        // R8 R4 parity error, even parity
        cfg_par_odd = 0; irq_en = 1;
        send(8'h5A, 8, 1, 0, 1, 1, 0, 1);
        chk("R8", {full, ovr_err, frm_err, par_err}, 4'b0001);
        chk("R8", rx_data, 8'h5A);
        chk("R11", irq_err, 1);
        // R9 further frame ignored while error held
        send(8'hC3, 8, 1, 0, 0, 1, 0, 1);
        chk("R9", rx_data, 8'h5A);
        chk("R9", full, 0);
        pulse_clr(0, 0, 0, 1);
        chk("R10", par_err, 0);
        chk("R11", irq_err, 0);

        // R8 R5 framing error, no parity
        cfg_par_en = 0;
        send(8'h81, 8, 0, 0, 0, 0, 0, 1);
        chk("R8", {full, ovr_err, frm_err, par_err}, 4'b0010);
        chk("R8", rx_data, 8'h81);
        send(8'h7E, 8, 0, 0, 0, 1, 0, 1);
        chk("R9", rx_data, 8'h81);
        chk("R9", full, 0);
        pulse_clr(0, 0, 1, 0);
        chk("R10", frm_err, 0);
        send(8'h7E, 8, 0, 0, 0, 1, 0, 1);
        check_clean("R9", 8'h7E);

        // R7 overrun: full still set
        send(8'h33, 8, 0, 0, 0, 1, 0, 1);
        chk("R7", {full, ovr_err, frm_err, par_err}, 4'b1100);
        chk("R7", rx_data, 8'h7E);
        chk("R11", irq_err, 1);
        chk("R11", irq_done, 1);
        pulse_clr(1, 1, 0, 0);
        chk("R10", {full, ovr_err}, 0);

        // R2 glitch shorter than half a bit
        rxd = 0; repeat (4) @(negedge clk); rxd = 1;
        repeat (300) @(negedge clk);
        chk("R2", full, 0);
        chk("R2", rx_data, 8'h7E);
        send(8'hA5, 8, 0, 0, 0, 1, 0, 1);
        check_clean("R2", 8'hA5);
        pulse_clr(1, 0, 0, 0);

        // R12 configuration changed mid-frame
        fork
            send(8'h96, 8, 0, 0, 0, 1, 0, 1);
            begin
                repeat (40) @(negedge clk);
                cfg_len7 = 1; cfg_par_en = 1; cfg_par_odd = 1;
            end
        join
        check_clean("R12", 8'h96);
        cfg_len7 = 0; cfg_par_en = 0; cfg_par_odd = 0;
        pulse_clr(1, 0, 0, 0);

        // R10 set wins over a simultaneous clear
        clr_full = 1;
        got = 0;
        fork
            send(8'h3C, 8, 0, 0, 0, 1, 0, 1);
            begin
                for (int k = 0; k < 400; k++) begin
                    @(negedge clk);
                    if (full) begin
                        clr_full = 0;
                        got = 1;
                        break;
                    end
                end
                clr_full = 0;
            end
        join
        chk("R10", got, 1);
        chk("R10", full, 1);
        m = rx_data;
        chk("R10", m, 8'h3C);

        finish_up();
    end

endmodule